// File: doc/BRIEF.md
# Calibration Request Sequencer

This block accepts calibration requests for two timing engines, a polling-timer engine (index 0) and an FSK receiver engine (index 1). It launches each engine with a start strobe and waits for that engine's done pulse. It then clears the request bit on its own and raises a completion flag that stays set. Software posts a request with a one-cycle write pulse. It reads the request bits to see whether the calibration is still outstanding, and reads the completion flags to see that it has finished.

In discontinuous (duty-cycled) receive mode, each wake-up pulse posts requests automatically. The polling request is always posted, and the FSK request is posted only when FSK reception is enabled. In continuous receive mode a wake-up pulse posts nothing.

A calibration is launched only while the crystal oscillator is enabled. When both requests are waiting, the polling calibration goes first, and only one engine runs at a time. The engines are outside this block.

Top module: `cal_seq_ctrl`

## Requirements
- R1: A pulse on `pcal_req_wr_i` sets `pcal_req_o` at the next clock edge and clears `pcal_done_o` at the same edge.
- R2: A pulse on `fcal_req_wr_i` sets `fcal_req_o` at the next clock edge and clears `fcal_done_o` at the same edge.
- R3: A launch is a single-cycle strobe on the start output of that engine. While the strobe is high, the matching request bit is high.
- R4: While an engine is running, its done pulse clears the matching request bit and sets the matching completion flag at the next edge. A completion flag stays set until a new request for that calibration is posted.
- R5: At most one engine runs at a time. No start strobe is issued while an engine is running. When both requests are pending, the polling calibration is launched first.
- R6: No start strobe follows a cycle in which `osc_en_i` was low. A request posted while the oscillator is disabled stays pending and is launched once the oscillator is enabled.
- R7: When `drx_mode_i` is 1 (discontinuous), a `wake_i` pulse sets `pcal_req_o`. It also sets `fcal_req_o` when `fsk_en_i` is 1.
- R8: When `drx_mode_i` is 0 (continuous), a `wake_i` pulse changes neither request bit.
- R9: A done pulse from an engine that is not running changes neither its request bit nor its completion flag.
- R10: After reset, all request bits, completion flags and start strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pcal_req_wr_i | input | 1 | Software write pulse that posts a polling calibration request |
| fcal_req_wr_i | input | 1 | Software write pulse that posts an FSK calibration request |
| drx_mode_i | input | 1 | 1 = discontinuous receive, 0 = continuous receive |
| fsk_en_i | input | 1 | FSK reception enabled |
| wake_i | input | 1 | Wake-up pulse from the duty-cycle timer |
| osc_en_i | input | 1 | Crystal oscillator running |
| pcal_done_i | input | 1 | Done pulse from the polling calibration engine |
| fcal_done_i | input | 1 | Done pulse from the FSK calibration engine |
| pcal_start_o | output | 1 | Start strobe to the polling calibration engine |
| fcal_start_o | output | 1 | Start strobe to the FSK calibration engine |
| pcal_req_o | output | 1 | Polling request pending |
| fcal_req_o | output | 1 | FSK request pending |
| pcal_done_o | output | 1 | Sticky polling calibration complete flag |
| fcal_done_o | output | 1 | Sticky FSK calibration complete flag |

## Verification
The checker follows which engine is running from the start strobes and the done pulses. On every cycle it confirms four things: strobes are single-cycle, launches are mutually exclusive and gated by the oscillator, completion flags are sticky and set by completion, and stray done pulses and continuous-mode wake-ups are ignored. Other properties need a sequence of events to show. These are the order polling-then-FSK when both requests are pending, a request held through a long oscillator-off period and launched afterwards, and the full set of wake-up combinations across mode and FSK enable. The bench's scenarios cover those.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned N_CAL   = 2;
  localparam int unsigned CAL_POLL = 0;
  localparam int unsigned CAL_FSK  = 1;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cal_st_e;
endpackage

// File: rtl/cal_req_slot.sv
// One request/completion bit pair; completion wins over a concurrent set.
module cal_req_slot (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic complete_i,
  output logic req_o,
  output logic done_o
);
  logic req_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      done_q <= 1'b0;
    end else if (complete_i) begin
      req_q  <= 1'b0;
      done_q <= 1'b1;
    end else if (set_i) begin
      req_q  <= 1'b1;
      done_q <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign done_o = done_q;
endmodule

// File: rtl/cal_wake_ctrl.sv
// Automatic requests on wake-up in discontinuous mode.
module cal_wake_ctrl #(
  parameter int unsigned N_CAL = 2,
  parameter int unsigned FSK_IDX = 1
) (
  input  logic             wake_i,
  input  logic             drx_mode_i,
  input  logic             fsk_en_i,
  output logic [N_CAL-1:0] auto_req_o
);
  logic [N_CAL-1:0] mask;

  for (genvar g = 0; g < N_CAL; g++) begin : g_mask
    if (g == FSK_IDX) begin : g_fsk
      assign mask[g] = fsk_en_i;
    end else begin : g_always
      assign mask[g] = 1'b1;
    end
  end

  assign auto_req_o = (wake_i && drx_mode_i) ? mask : '0;
endmodule

// File: rtl/cal_arbiter.sv
// Fixed-priority launcher: lowest index first, one engine at a time.
module cal_arbiter
  import cal_pkg::*;
#(
  parameter int unsigned N_CAL = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_CAL-1:0] req_i,
  input  logic             osc_en_i,
  input  logic [N_CAL-1:0] eng_done_i,
  output logic [N_CAL-1:0] start_o,
  output logic [N_CAL-1:0] complete_o
);
  localparam int unsigned IDX_W = (N_CAL > 1) ? $clog2(N_CAL) : 1;

  cal_st_e          st_q;
  logic [IDX_W-1:0] act_q;
  logic [N_CAL-1:0] start_q;
  logic [IDX_W-1:0] pick;
  logic             any_req;
  logic             launch;
  logic             finish;

  always_comb begin
    pick    = '0;
    any_req = 1'b0;
    for (int i = N_CAL - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        pick    = IDX_W'(i);
        any_req = 1'b1;
      end
    end
  end

  assign launch = (st_q == ST_IDLE) && any_req && osc_en_i;
  assign finish = (st_q == ST_RUN) && eng_done_i[act_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      act_q   <= '0;
      start_q <= '0;
    end else begin
      start_q <= '0;
      if (launch) begin
        st_q         <= ST_RUN;
        act_q        <= pick;
        start_q[pick] <= 1'b1;
      end else if (finish) begin
        st_q <= ST_IDLE;
      end
    end
  end

  always_comb begin
    complete_o = '0;
    if (finish) complete_o[act_q] = 1'b1;
  end

  assign start_o = start_q;
endmodule

// File: rtl/cal_seq_ctrl.sv
module cal_seq_ctrl
  import cal_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pcal_req_wr_i,
  input  logic fcal_req_wr_i,
  input  logic drx_mode_i,
  input  logic fsk_en_i,
  input  logic wake_i,
  input  logic osc_en_i,
  input  logic pcal_done_i,
  input  logic fcal_done_i,
  output logic pcal_start_o,
  output logic fcal_start_o,
  output logic pcal_req_o,
  output logic fcal_req_o,
  output logic pcal_done_o,
  output logic fcal_done_o
);
  logic [N_CAL-1:0] wr_req, auto_req, set_req;
  logic [N_CAL-1:0] req, done, start, complete, eng_done;

  assign wr_req[CAL_POLL]   = pcal_req_wr_i;
  assign wr_req[CAL_FSK]    = fcal_req_wr_i;
  assign eng_done[CAL_POLL] = pcal_done_i;
  assign eng_done[CAL_FSK]  = fcal_done_i;

  cal_wake_ctrl #(.N_CAL(N_CAL), .FSK_IDX(CAL_FSK)) u_wake (
    .wake_i     (wake_i),
    .drx_mode_i (drx_mode_i),
    .fsk_en_i   (fsk_en_i),
    .auto_req_o (auto_req)
  );

  assign set_req = wr_req | auto_req;

  for (genvar g = 0; g < N_CAL; g++) begin : g_slot
    cal_req_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (set_req[g]),
      .complete_i (complete[g]),
      .req_o      (req[g]),
      .done_o     (done[g])
    );
  end

  cal_arbiter #(.N_CAL(N_CAL)) u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .osc_en_i   (osc_en_i),
    .eng_done_i (eng_done),
    .start_o    (start),
    .complete_o (complete)
  );

  assign pcal_start_o = start[CAL_POLL];
  assign fcal_start_o = start[CAL_FSK];
  assign pcal_req_o   = req[CAL_POLL];
  assign fcal_req_o   = req[CAL_FSK];
  assign pcal_done_o  = done[CAL_POLL];
  assign fcal_done_o  = done[CAL_FSK];
endmodule

// File: rtl/cal_seq_ctrl_chk.sv
module cal_seq_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic pcal_req_wr_i,
  input logic fcal_req_wr_i,
  input logic drx_mode_i,
  input logic fsk_en_i,
  input logic wake_i,
  input logic osc_en_i,
  input logic pcal_done_i,
  input logic fcal_done_i,
  input logic pcal_start_o,
  input logic fcal_start_o,
  input logic pcal_req_o,
  input logic fcal_req_o,
  input logic pcal_done_o,
  input logic fcal_done_o
);
  // Engine activity rebuilt from port traffic.
  logic run_p_q, run_f_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_p_q <= 1'b0;
      run_f_q <= 1'b0;
    end else begin
      run_p_q <= (run_p_q | pcal_start_o) & ~pcal_done_i;
      run_f_q <= (run_f_q | fcal_start_o) & ~fcal_done_i;
    end
  end

  assert_pstart_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pcal_start_o |=> !pcal_start_o);
  assert_fstart_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcal_start_o |=> !fcal_start_o);
  assert_start_has_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcal_start_o |-> pcal_req_o) and (fcal_start_o |-> fcal_req_o));
  assert_done_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((run_p_q || pcal_start_o) && pcal_done_i) |=> (pcal_done_o && !pcal_req_o));
  assert_pdone_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pcal_done_o) |-> pcal_req_o);
  assert_fdone_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fcal_done_o) |-> fcal_req_o);
  assert_one_start_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pcal_start_o, fcal_start_o}));
  assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcal_start_o || fcal_start_o) |-> !(run_p_q || run_f_q));
  assert_osc_gate_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcal_start_o || fcal_start_o) |-> $past(osc_en_i));
  assert_cont_wake_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_i && !drx_mode_i && !pcal_req_o && !pcal_req_wr_i) |=> !pcal_req_o);
  assert_stray_done_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fcal_done_i && !(run_f_q || fcal_start_o) && !fcal_done_o) |=> !fcal_done_o);
endmodule

bind cal_seq_ctrl cal_seq_ctrl_chk u_chk (.*);

// File: tb/tb_cal_seq_ctrl.sv
`timescale 1ns/1ps
module tb_cal_seq_ctrl;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic pcal_req_wr_i = 0, fcal_req_wr_i = 0, drx_mode_i = 0, fsk_en_i = 0;
  logic wake_i = 0, osc_en_i = 0;
  logic pcal_done_i, fcal_done_i;
  logic pcal_start_o, fcal_start_o, pcal_req_o, fcal_req_o, pcal_done_o, fcal_done_o;

  int n_checks = 0, n_fail = 0;
  localparam int LAT = 5;

  always #5 clk_i = ~clk_i;

  cal_seq_ctrl dut (.*);

  // Engine stubs: done pulse LAT cycles after start, plus a manual override.
  logic stub_p, stub_f, man_p = 0, man_f = 0;
  int cnt_p = 0, cnt_f = 0;
  always @(posedge clk_i) begin
    stub_p <= 1'b0;
    stub_f <= 1'b0;
    if (pcal_start_o) cnt_p <= LAT;
    else if (cnt_p > 0) begin cnt_p <= cnt_p - 1; if (cnt_p == 1) stub_p <= 1'b1; end
    if (fcal_start_o) cnt_f <= LAT;
    else if (cnt_f > 0) begin cnt_f <= cnt_f - 1; if (cnt_f == 1) stub_f <= 1'b1; end
  end
  assign pcal_done_i = stub_p | man_p;
  assign fcal_done_i = stub_f | man_f;

  // Start log
  int n_ps = 0, n_fs = 0, ev_n = 0;
  logic [1:0] ev [4];
  always @(negedge clk_i) begin
    if (pcal_start_o) begin n_ps++; if (ev_n < 4) ev[ev_n] = 2'd1; ev_n++; end
    if (fcal_start_o) begin n_fs++; if (ev_n < 4) ev[ev_n] = 2'd2; ev_n++; end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0;
    {pcal_req_wr_i, fcal_req_wr_i, wake_i, osc_en_i, man_p, man_f} = '0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    n_ps = 0; n_fs = 0; ev_n = 0;
  endtask

  typedef struct packed {
    logic drx, fsk, pwr, fwr, wake, ep, ef;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{0,0,1,0,0,1,0},  // R1
    '{0,0,0,1,0,0,1},  // R2
    '{1,0,0,0,1,1,0},  // R7
    '{1,1,0,0,1,1,1},  // R7
    '{0,1,0,0,1,0,0},  // R8
    '{0,0,0,0,1,0,0},  // R8
    '{1,1,0,0,0,0,0},  // no wake
    '{0,1,1,1,1,1,1}   // R1 R2
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    // R10 reset state
    do_reset();
    chk({pcal_req_o, fcal_req_o, pcal_done_o, fcal_done_o, pcal_start_o, fcal_start_o} == 0,
        "R10 reset", {pcal_req_o, fcal_req_o, pcal_done_o, fcal_done_o}, 0);

    // Vector table: one cycle of stimulus with oscillator off, then request bits.
    foreach (VECS[i]) begin
      do_reset();
      drx_mode_i = VECS[i].drx; fsk_en_i = VECS[i].fsk;
      pcal_req_wr_i = VECS[i].pwr; fcal_req_wr_i = VECS[i].fwr; wake_i = VECS[i].wake;
      @(negedge clk_i);
      {pcal_req_wr_i, fcal_req_wr_i, wake_i} = '0;
      chk(pcal_req_o == VECS[i].ep, $sformatf("R1/R7/R8 vec%0d pcal_req", i), pcal_req_o, VECS[i].ep);
      chk(fcal_req_o == VECS[i].ef, $sformatf("R2/R7/R8 vec%0d fcal_req", i), fcal_req_o, VECS[i].ef);
    end

    // R6: pending request held while oscillator off, launched after enable.
    do_reset();
    drx_mode_i = 0;
    pcal_req_wr_i = 1; fcal_req_wr_i = 1;
    @(negedge clk_i);
    {pcal_req_wr_i, fcal_req_wr_i} = '0;
    repeat (12) @(negedge clk_i);
    chk(n_ps + n_fs == 0, "R6 no start with osc off", n_ps + n_fs, 0);
    chk(pcal_req_o && fcal_req_o, "R6 requests held", {pcal_req_o, fcal_req_o}, 3);

    // R9: stray FSK done while idle.
    man_f = 1;
    @(negedge clk_i);
    man_f = 0;
    chk(fcal_req_o == 1 && fcal_done_o == 0, "R9 stray done ignored",
        {fcal_req_o, fcal_done_o}, 2);

    // R5/R3/R4: enable oscillator, polling then FSK.
    osc_en_i = 1;
    @(negedge clk_i);
    chk(pcal_start_o == 1 && fcal_start_o == 0, "R5 polling launched first",
        {pcal_start_o, fcal_start_o}, 2);
    @(negedge clk_i);
    chk(pcal_start_o == 0, "R3 single-cycle strobe", pcal_start_o, 0);
    for (int k = 0; k < 40 && !(pcal_done_o && fcal_done_o); k++) @(negedge clk_i);
    chk(pcal_done_o && fcal_done_o, "R4 both done flags set", {pcal_done_o, fcal_done_o}, 3);
    chk(!pcal_req_o && !fcal_req_o, "R4 requests self-cleared", {pcal_req_o, fcal_req_o}, 0);
    chk(n_ps == 1 && n_fs == 1, "R5 one launch each", n_ps * 10 + n_fs, 11);
    chk(ev[0] == 2'd1 && ev[1] == 2'd2, "R5 order polling then fsk", {ev[0], ev[1]}, 6);

    // R4 sticky, R9 stray polling done after completion.
    man_p = 1;
    @(negedge clk_i);
    man_p = 0;
    repeat (5) @(negedge clk_i);
    chk(pcal_done_o == 1 && pcal_req_o == 0, "R4/R9 done flag sticky", {pcal_req_o, pcal_done_o}, 1);

    // R1: new write clears done flag; launch follows.
    osc_en_i = 0;
    pcal_req_wr_i = 1;
    @(negedge clk_i);
    pcal_req_wr_i = 0;
    chk(pcal_req_o == 1 && pcal_done_o == 0, "R1 write clears done", {pcal_req_o, pcal_done_o}, 2);
    chk(fcal_done_o == 1, "R2 other flag kept", fcal_done_o, 1);

    // R7: wake in discontinuous mode with FSK enabled, full cycle.
    do_reset();
    drx_mode_i = 1; fsk_en_i = 1; osc_en_i = 1;
    wake_i = 1;
    @(negedge clk_i);
    wake_i = 0;
    for (int k = 0; k < 40 && !(pcal_done_o && fcal_done_o); k++) @(negedge clk_i);
    chk(pcal_done_o && fcal_done_o && n_ps == 1 && n_fs == 1, "R7 wake calibrates both",
        {pcal_done_o, fcal_done_o}, 3);

    // R7: wake with FSK disabled calibrates polling only.
    do_reset();
    drx_mode_i = 1; fsk_en_i = 0; osc_en_i = 1;
    wake_i = 1;
    @(negedge clk_i);
    wake_i = 0;
    repeat (20) @(negedge clk_i);
    chk(pcal_done_o && !fcal_done_o && n_fs == 0, "R7 fsk disabled polling only",
        {pcal_done_o, fcal_done_o}, 2);

    // R8: continuous mode wake with oscillator on never launches.
    do_reset();
    drx_mode_i = 0; fsk_en_i = 1; osc_en_i = 1;
    wake_i = 1;
    @(negedge clk_i);
    wake_i = 0;
    repeat (10) @(negedge clk_i);
    chk(n_ps + n_fs == 0 && !pcal_req_o, "R8 continuous wake ignored", n_ps + n_fs, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule